// File: doc/BRIEF.md
# DDR SDRAM Power-Up Sequencer

This block brings a DDR SDRAM out of power-up on its own, with no processor writing command registers. After reset it sits idle with the clock enable low and the command pins deselected. A single-cycle start pulse launches a fixed program. The program raises the clock enable, precharges every bank, loads the extended mode register and then the mode register with the DLL held in reset. After a long settling wait it precharges again, issues two auto-refresh commands and loads the mode register a second time with the DLL reset cleared. Once the last wait has elapsed, a done flag goes high and stays high.

The command port is a single-phase DFI-style interface. It has active-low chip select, row strobe, column strobe and write enable, a clock enable, a row/mode address and a bank address. Each command occupies exactly one clock cycle. A shared down-counter then holds the port at NOP for a number of cycles that depends on the step just issued. Three parameters set these waits: a general gap, a long wait after mode register loads, and a short wait after refreshes. The mode word fixes CAS latency 3 and burst length 4. The reset input is asserted asynchronously and released through a two-stage synchronizer, so the block accepts start only from the third rising edge after reset goes high.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, cke is 0, cs_n, ras_n, cas_n and we_n are all 1, addr and ba are 0 and done is 0. Asserting reset in the middle of a sequence returns the outputs to these values at once.
- R2: Before a start pulse the outputs hold their reset values. In the cycle after start is sampled high, cke is 1 and the command pins still show NOP, with addr 0 and ba 0.
- R3: Commands are written as {cs_n,ras_n,cas_n,we_n}: NOP 4'b1111, precharge-all 4'b0010, mode register load 4'b0000, auto refresh 4'b0001. After the clock-enable step they appear in this order: precharge-all, extended load, mode load, precharge-all, refresh, refresh, mode load.
- R4: Precharge-all drives addr 13'h0400 (bit 10 set) and ba 0.
- R5: The extended mode register load drives ba 1 and addr 0. The first mode register load drives ba 0 and addr 13'h0132 (DLL reset bit 8, CAS latency 3 in bits 6:4, burst-length-4 code 2 in bits 2:0). The final load drives ba 0 and addr 13'h0032.
- R6: Both auto-refresh commands drive addr 0 and ba 0.
- R7: Each command lasts exactly one cycle. In every cycle without a command, all four command pins are 1.
- R8: Between two consecutive steps the port shows exactly N NOP cycles. N is T_LONG after a mode register load, T_SHORT after a refresh, and T_GAP after the clock-enable step, a precharge or the extended load.
- R9: done goes to 1 in the cycle that falls T_LONG+1 cycles after the final mode load. It then stays 1 with cke 1 until reset.
- R10: A start pulse while the sequence is running, or after done, has no effect on the command port, the wait timing or done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| start | input | 1 | Start pulse, sampled only while idle |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Active-low chip select |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | 1 | Active-low column strobe |
| we_n | output | 1 | Active-low write enable |
| addr | output | ADDR_W (13) | Address / mode word |
| ba | output | BA_W (2) | Bank address |
| done | output | 1 | Sequence finished, sticky until reset |

## Verification
The in-RTL properties check the following on every cycle: commands never last longer than one cycle, a command is only issued with cke high, cke and done never fall outside reset, no command follows done, and the wait counter steps down by one. The command order, the address and bank values of each step, the exact NOP count between steps and the exact cycle in which done rises all depend on the whole sequence. Only the bench's walk through the expected step table can show them. That also holds for the effect of start pulses given mid-sequence or after completion, and for a reset in the middle of a run.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  // Command pins, active low, in {cs_n, ras_n, cas_n, we_n} order
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_NOP  = cmd_t'(4'b1111);
  localparam cmd_t CMD_PREA = cmd_t'(4'b0010);
  localparam cmd_t CMD_LMR  = cmd_t'(4'b0000);
  localparam cmd_t CMD_REF  = cmd_t'(4'b0001);

  // Which wait follows a step
  typedef enum logic [1:0] {
    W_GAP   = 2'd0,
    W_LONG  = 2'd1,
    W_SHORT = 2'd2
  } wsel_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_DONE  = 2'd3
  } st_e;

  localparam int NUM_STEPS = 8;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  // Mode word fields
  localparam logic [2:0] CAS_LAT     = 3'd3;
  localparam logic [2:0] BURST_CODE  = 3'd2;
  localparam int         DLL_RST_BIT = 8;
  localparam int         ALL_BANKS_BIT = 10;

endpackage

// File: rtl/ddr_init_rstsync.sv
module ddr_init_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ddr_init_steps.sv
module ddr_init_steps
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic [STEP_W-1:0] step,
  output cmd_t              cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output wsel_e             wsel
);

  function automatic logic [ADDR_W-1:0] mode_word(input logic dll_rst);
    logic [ADDR_W-1:0] w;
    w = '0;
    w[2:0] = BURST_CODE;
    w[6:4] = CAS_LAT;
    w[DLL_RST_BIT] = dll_rst;
    return w;
  endfunction

  localparam logic [ADDR_W-1:0] PREA_ADDR = ADDR_W'(1) << ALL_BANKS_BIT;

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    wsel = W_GAP;
    case (step)
      STEP_W'(0): begin cmd = CMD_NOP;  wsel = W_GAP; end
      STEP_W'(1): begin cmd = CMD_PREA; addr = PREA_ADDR; wsel = W_GAP; end
      STEP_W'(2): begin cmd = CMD_LMR;  ba = BA_W'(1); wsel = W_GAP; end
      STEP_W'(3): begin cmd = CMD_LMR;  addr = mode_word(1'b1); wsel = W_LONG; end
      STEP_W'(4): begin cmd = CMD_PREA; addr = PREA_ADDR; wsel = W_GAP; end
      STEP_W'(5): begin cmd = CMD_REF;  wsel = W_SHORT; end
      STEP_W'(6): begin cmd = CMD_REF;  wsel = W_SHORT; end
      default:    begin cmd = CMD_LMR;  addr = mode_word(1'b0); wsel = W_LONG; end
    endcase
  end
endmodule

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == CNT_W'(1));

  // R8: a running count falls by exactly one per cycle
  p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int T_GAP   = 2,
  parameter int T_LONG  = 200,
  parameter int T_SHORT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              done
);

  localparam int MAX_A    = (T_GAP > T_SHORT) ? T_GAP : T_SHORT;
  localparam int MAX_WAIT = (MAX_A > T_LONG) ? MAX_A : T_LONG;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  logic rst_s_n;
  ddr_init_rstsync i_rstsync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  st_e               state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;
  logic              load;
  logic              expire;
  logic [CNT_W-1:0]  wait_val;

  cmd_t              rom_cmd;
  logic [ADDR_W-1:0] rom_addr;
  logic [BA_W-1:0]   rom_ba;
  wsel_e             rom_wsel;

  ddr_init_steps #(.ADDR_W(ADDR_W), .BA_W(BA_W)) i_steps (
    .step(step_q), .cmd(rom_cmd), .addr(rom_addr), .ba(rom_ba), .wsel(rom_wsel)
  );

  always_comb begin
    case (rom_wsel)
      W_LONG:  wait_val = CNT_W'(T_LONG);
      W_SHORT: wait_val = CNT_W'(T_SHORT);
      default: wait_val = CNT_W'(T_GAP);
    endcase
  end

  ddr_init_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst_n(rst_s_n), .load(load), .load_val(wait_val), .expire(expire)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    load    = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          state_d = S_ISSUE;
          step_d  = '0;
        end
      end
      S_ISSUE: begin
        load    = 1'b1;
        state_d = S_WAIT;
      end
      S_WAIT: begin
        if (expire) begin
          if (step_q == LAST_STEP) begin
            state_d = S_DONE;
          end else begin
            state_d = S_ISSUE;
            step_d  = step_q + STEP_W'(1);
          end
        end
      end
      default: state_d = S_DONE;
    endcase
  end

  assign step_en = (step_d != step_q);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) state_q <= S_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  // Output decode
  logic issuing;
  cmd_t cmd_o;
  assign issuing = (state_q == S_ISSUE);
  assign cmd_o   = issuing ? rom_cmd : CMD_NOP;
  assign cs_n    = cmd_o.cs_n;
  assign ras_n   = cmd_o.ras_n;
  assign cas_n   = cmd_o.cas_n;
  assign we_n    = cmd_o.we_n;
  assign addr    = issuing ? rom_addr : '0;
  assign ba      = issuing ? rom_ba : '0;
  assign cke     = (state_q != S_IDLE);
  assign done    = (state_q == S_DONE);

  // R7: a command never lasts beyond one cycle
  p_one_cycle_cmd_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cs_n |=> cs_n);
  // R2: commands only with the clock enable high
  p_cmd_with_cke_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cs_n |-> cke);
  // R9: done and cke hold once raised
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> done);
  p_cke_hold_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    cke |=> cke);
  // R10: no command follows completion
  p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |-> (cs_n && ras_n && cas_n && we_n));
endmodule

// File: tb/test_ddr_init_seq.sv
module test_ddr_init_seq;
  localparam int T_GAP = 2, T_LONG = 200, T_SHORT = 4;

  logic clk = 1'b0;
  logic rst_n, start;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [12:0] addr;
  logic [1:0]  ba;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ddr_init_seq #(.ADDR_W(13), .BA_W(2), .T_GAP(T_GAP), .T_LONG(T_LONG), .T_SHORT(T_SHORT))
    i_ddr_init_seq (.clk(clk), .rst_n(rst_n), .start(start), .cke(cke), .cs_n(cs_n),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .done(done));

  // Expected step table: {cs_n,ras_n,cas_n,we_n}, addr, ba, NOP cycles after
  localparam logic [3:0]  EXP_CMD  [8] = '{4'b1111, 4'b0010, 4'b0000, 4'b0000,
                                           4'b0010, 4'b0001, 4'b0001, 4'b0000};
  localparam logic [12:0] EXP_ADDR [8] = '{13'h0, 13'h400, 13'h0, 13'h132,
                                           13'h400, 13'h0, 13'h0, 13'h032};
  localparam logic [1:0]  EXP_BA   [8] = '{2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
  localparam int          EXP_WAIT [8] = '{T_GAP, T_GAP, T_GAP, T_LONG,
                                           T_GAP, T_SHORT, T_SHORT, T_LONG};
  localparam string       EXP_REQ  [8] = '{"R2", "R4", "R5", "R5", "R4", "R6", "R6", "R5"};

  function automatic logic [3:0] cmd_now();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic chk_reset_outputs(input string req);
    chk(cke == 1'b0, req, "cke", 32'(cke), 32'd0);
    chk(cmd_now() == 4'b1111, req, "cmd", 32'(cmd_now()), 32'hf);
    chk(addr == '0 && ba == '0, req, "addr/ba", {17'd0, ba, addr}, 32'd0);
    chk(done == 1'b0, req, "done", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int bad_nop;
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) tick();
    // R1: reset state
    chk_reset_outputs("R1");
    rst_n = 1'b1;
    repeat (4) tick();
    // R2: idle without start
    repeat (10) tick();
    chk_reset_outputs("R2");

    pulse_start();
    chk(cke == 1'b1, "R2", "cke after start", 32'(cke), 32'd1);

    // Walk the step table
    bad_nop = 0;
    for (int k = 0; k < 8; k++) begin
      if (k > 0) tick();
      // R3 order and encoding
      chk(cmd_now() == EXP_CMD[k], "R3", $sformatf("step %0d cmd", k),
          32'(cmd_now()), 32'(EXP_CMD[k]));
      chk(addr == EXP_ADDR[k], EXP_REQ[k], $sformatf("step %0d addr", k),
          32'(addr), 32'(EXP_ADDR[k]));
      chk(ba == EXP_BA[k], EXP_REQ[k], $sformatf("step %0d ba", k),
          32'(ba), 32'(EXP_BA[k]));
      for (int j = 0; j < EXP_WAIT[k]; j++) begin
        if (k == 3 && j == 50) begin
          start = 1'b1;   // R10: start while busy
          tick();
          start = 1'b0;
        end else begin
          tick();
        end
        if (cmd_now() != 4'b1111 || !cke || done) bad_nop++;
      end
      // R7, R8: exact NOP gap, no stray command
      chk(bad_nop == 0, "R8", $sformatf("nop gap after step %0d", k), 32'(bad_nop), 32'd0);
      bad_nop = 0;
    end
    chk(done == 1'b0, "R9", "done early", 32'(done), 32'd0);
    tick();
    chk(done == 1'b1, "R9", "done on time", 32'(done), 32'd1);
    chk(cke == 1'b1, "R9", "cke held", 32'(cke), 32'd1);

    // R10: start after done ignored
    pulse_start();
    bad_nop = 0;
    for (int j = 0; j < 30; j++) begin
      if (cmd_now() != 4'b1111 || !done || !cke) bad_nop++;
      tick();
    end
    chk(bad_nop == 0, "R10", "start after done", 32'(bad_nop), 32'd0);

    // R1: reset mid-sequence
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    pulse_start();
    repeat (5) tick();
    rst_n = 1'b0;
    #1;
    chk_reset_outputs("R1");
    tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R7: restart shows one-cycle precharge after T_GAP NOPs
    pulse_start();
    repeat (T_GAP + 1) tick();
    chk(cmd_now() == 4'b0010, "R7", "restart precharge", 32'(cmd_now()), 32'h2);
    tick();
    chk(cmd_now() == 4'b1111, "R7", "one-cycle command", 32'(cmd_now()), 32'hf);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule